// File: doc/BRIEF.md
# Link Wake Request Generator

This block lives in the physical layer of a serial bus controller. It asks a powered-down or disabled link-layer controller to wake up. It watches the link's power-status input and the link-control register bit. It also watches a pulse that marks a received link-on packet addressed to this node, and the interrupt flags held elsewhere. When the link is down and a wake cause appears, the block drives a square wave on its output until the link comes up.

The shared pin is split at the pad into three signals: an output value, an output enable and an input level. While hardware reset is held, the output enable is off and the pin level is captured as the default bus-manager contender status. After reset, the pin carries the wake signal.

A wake caused only by a packet is withdrawn by a bus reset. A wake caused by an interrupt condition survives a bus reset. An interrupt condition that is present while the link is up raises the wake as soon as the link goes down again.

Top module: `lkon_wake_gen`

## Requirements
- R1: While a wake request is held, `lkon_o` is a square wave with a period of 8 clock cycles. It is high for 4 cycles and then low for 4 cycles. The first high phase starts in the first cycle of the request and lasts a full 4 cycles.
- R2: While `rst_i` is high, `lkon_oe_o` is 0 and `lkon_o` is 0. Outside reset, `lkon_oe_o` is 1 and `lkon_o` is 0 whenever no request is held.
- R3: `contender_o` takes the level of `lkon_pin_i` sampled at the last clock edge with `rst_i` high. It holds that value until the next reset.
- R4: The link is up only when the synchronized `lps_i` is 1 and `lctl_i` is 1. `lps_i` passes through two flops before use, so a rise of `lps_i` ends a request at the third rising edge, while a rise of `lctl_i` (with `lps_i` already settled) ends it at the next edge.
- R5: While the link is down, a request starts at the next edge on any of these causes:
  - `pkt_wake_i` is high;
  - `irq_port_ev_i` is high;
  - `irq_cfg_to_i`, `irq_cab_pwr_i` or `irq_st_to_i` is high while `resume_en_i` is high.

  The last three flags have no effect while `resume_en_i` is 0.
- R6: Once started, a request stays held while the link is down, even after its cause is removed.
- R7: A bus reset (`bus_rst_i` high for one cycle) ends a request at the next edge unless a qualifying interrupt condition is present in that cycle. If one is present, the square wave continues without a break in phase.
- R8: A qualifying interrupt condition that is present while the link is up has no effect at the time. It starts a request at the first edge after the link goes down.
- R9: A link-on packet pulse that arrives while the link is up is not remembered. A later drop of the link without any other cause leaves `lkon_o` low.
- R10: `lkon_o` is low in the first cycle after a request ends. A new request restarts the phase, so its first high phase again lasts 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Hardware reset, active high, synchronous |
| lps_i | input | 1 | Link power status, asynchronous |
| lctl_i | input | 1 | Link-control register bit |
| pkt_wake_i | input | 1 | One-cycle pulse: link-on packet for this node received |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset occurred |
| irq_port_ev_i | input | 1 | Port-event interrupt flag |
| irq_cfg_to_i | input | 1 | Configuration-timeout interrupt flag |
| irq_cab_pwr_i | input | 1 | Cable-power-status interrupt flag |
| irq_st_to_i | input | 1 | State-timeout interrupt flag |
| resume_en_i | input | 1 | Resuming-port interrupt enable |
| lkon_pin_i | input | 1 | Level seen at the shared pin |
| lkon_o | output | 1 | Wake output value to the pad |
| lkon_oe_o | output | 1 | Pad output enable (0 = high impedance) |
| contender_o | output | 1 | Contender default latched during reset |

## Verification
On every cycle the assertions check the following:
- the request drops one edge after the link is seen up;
- a request persists while the link stays down;
- a qualifying interrupt always raises or holds the request, even across a bus reset;
- a bus reset with no interrupt clears the request;
- the wave changes level only at the counter's half and wrap points;
- the contender value never moves outside reset.

The bench's scenarios are needed for the rest:
- the exact 4-high/4-low cycle sequence seen at the pin;
- the three-edge latency through the power-status synchronizer;
- the gating by the resume enable;
- forgetting a packet that arrives while the link is up;
- the phase restart on a new request;
- the pad enable and contender capture around reset.

// File: rtl/lkon_pkg.sv
package lkon_pkg;

  // Link counts as up only with both power status and control bit set.
  function automatic logic f_link_up(input logic lps_s, input logic lctl);
    return lps_s & lctl;
  endfunction

  // Interrupt-driven wake cause: port event always, the other three only
  // when the resume enable is set.
  function automatic logic f_irq_wake(input logic port_ev, input logic cfg_to,
                                      input logic cab_pwr, input logic st_to,
                                      input logic resume_en);
    return port_ev | (resume_en & (cfg_to | cab_pwr | st_to));
  endfunction

  // Square-wave level: high in the lower half of the counter range.
  function automatic logic f_wave_level(input logic req, input logic cnt_msb);
    return req & ~cnt_msb;
  endfunction

endpackage

// File: rtl/lkon_sync.sv
module lkon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) shreg <= '0;
        else       shreg <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) shreg <= '0;
        else       shreg <= {shreg[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/lkon_req_ctl.sv
module lkon_req_ctl (
  input  logic clk_i,
  input  logic rst_i,
  input  logic link_up_i,
  input  logic pkt_wake_i,
  input  logic bus_rst_i,
  input  logic irq_wake_i,
  output logic req_o
);
  logic pkt_q;   // sticky: packet-caused request
  logic irq_q;   // interrupt-caused request

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pkt_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (link_up_i || bus_rst_i) pkt_q <= 1'b0;
      else if (pkt_wake_i)        pkt_q <= 1'b1;

      if (link_up_i)       irq_q <= 1'b0;
      else if (irq_wake_i) irq_q <= 1'b1;
      else if (bus_rst_i)  irq_q <= 1'b0;
    end
  end

  assign req_o = pkt_q | irq_q;

  AST_LINK_UP_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    link_up_i |=> !req_o);  // R4
  AST_HOLD_WHILE_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_o && !link_up_i && !bus_rst_i) |=> req_o);  // R6
  AST_IRQ_RAISES: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_wake_i && !link_up_i) |=> req_o);  // R8
  AST_BUS_RST_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_rst_i && !irq_wake_i) |=> !req_o);  // R7
endmodule

// File: rtl/lkon_wave.sv
module lkon_wave
  import lkon_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic wave_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1 << (CNT_W - 1));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !req_i) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign wave_o = f_wave_level(req_i, cnt_q[CNT_W-1]);

  AST_FIRST_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(req_i) |-> wave_o);  // R10
  AST_EDGE_AT_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && $past(req_i) && (wave_o != $past(wave_o))) |->
      (cnt_q == '0 || cnt_q == HALF));  // R1
endmodule

// File: rtl/lkon_wake_gen.sv
module lkon_wake_gen
  import lkon_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lps_i,
  input  logic lctl_i,
  input  logic pkt_wake_i,
  input  logic bus_rst_i,
  input  logic irq_port_ev_i,
  input  logic irq_cfg_to_i,
  input  logic irq_cab_pwr_i,
  input  logic irq_st_to_i,
  input  logic resume_en_i,
  input  logic lkon_pin_i,
  output logic lkon_o,
  output logic lkon_oe_o,
  output logic contender_o
);
  // Named internal events, visible to assertions.
  logic lps_sync;
  logic link_up;
  logic irq_wake;
  logic wake_req;
  logic wave;
  logic contender_q;

  lkon_sync #(.STAGES(SYNC_STAGES)) u_lps_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (lps_i),
    .q_o   (lps_sync)
  );

  assign link_up  = f_link_up(lps_sync, lctl_i);
  assign irq_wake = f_irq_wake(irq_port_ev_i, irq_cfg_to_i, irq_cab_pwr_i,
                               irq_st_to_i, resume_en_i);

  lkon_req_ctl u_req (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .link_up_i  (link_up),
    .pkt_wake_i (pkt_wake_i),
    .bus_rst_i  (bus_rst_i),
    .irq_wake_i (irq_wake),
    .req_o      (wake_req)
  );

  lkon_wave #(.CNT_W(CNT_W)) u_wave (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (wake_req),
    .wave_o (wave)
  );

  // Pin is an input during reset; its level becomes the contender default.
  always_ff @(posedge clk_i) begin
    if (rst_i) contender_q <= lkon_pin_i;
  end

  assign contender_o = contender_q;
  assign lkon_oe_o   = ~rst_i;
  assign lkon_o      = wave & ~rst_i;

  AST_CONTENDER_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> $stable(contender_o));  // R3
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (link_up && !irq_wake) |=> !lkon_o);  // R2
endmodule

// File: tb/lkon_wake_gen_tb.sv
`timescale 1ns/1ps
module lkon_wake_gen_tb;
  logic clk = 1'b0;
  logic rst, lps, lctl, pkt, brst, pe, cfg, cab, st, ren, pin;
  logic lkon, oe, cont;

  always #2.5 clk = ~clk;

  lkon_wake_gen u_dut (
    .clk_i (clk), .rst_i (rst), .lps_i (lps), .lctl_i (lctl),
    .pkt_wake_i (pkt), .bus_rst_i (brst), .irq_port_ev_i (pe),
    .irq_cfg_to_i (cfg), .irq_cab_pwr_i (cab), .irq_st_to_i (st),
    .resume_en_i (ren), .lkon_pin_i (pin), .lkon_o (lkon),
    .lkon_oe_o (oe), .contender_o (cont)
  );

  typedef struct { logic v; string tag; } exp_t;
  exp_t sb_q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver side: push n expected output levels, then let n cycles pass.
  task automatic expect_lvl(input logic v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.v = v;
      e.tag = tag;
      sb_q.push_back(e);
    end
    repeat (n) @(negedge clk);
  endtask

  // Monitor: one expected item per rising edge, sampled after it settles.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(lkon, e.v, e.tag);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; lps = 0; lctl = 0; pkt = 0; brst = 0; pe = 1; cfg = 0;
    cab = 0; st = 0; ren = 0; pin = 1;
    repeat (3) @(negedge clk);
    check(oe, 1'b0, "R2 oe in reset");
    check(lkon, 1'b0, "R2 out in reset");
    pe = 0; rst = 0; pin = 0;
    @(negedge clk);
    check(cont, 1'b1, "R3 contender high");
    check(oe, 1'b1, "R2 oe after reset");
    check(lkon, 1'b0, "R2 idle low");

    // Port-event wake, persistence, then link up through the synchronizer.
    pe = 1;
    expect_lvl(1, 4, "R5 port event high");
    pe = 0;
    expect_lvl(0, 4, "R1 low phase");
    expect_lvl(1, 4, "R6 held high");
    expect_lvl(0, 4, "R6 held low");
    lps = 1; lctl = 1;
    expect_lvl(1, 2, "R4 sync latency");
    expect_lvl(0, 6, "R4 link up ends");

    // Packet wake with control bit cleared, then bus reset.
    lctl = 0; pkt = 1;
    expect_lvl(1, 1, "R5 packet");
    pkt = 0;
    expect_lvl(1, 3, "R1 high phase");
    expect_lvl(0, 4, "R1 low phase");
    expect_lvl(1, 1, "R1 second high");
    brst = 1;
    expect_lvl(0, 1, "R7 bus reset drops");
    brst = 0;
    expect_lvl(0, 6, "R7 stays low");
    pkt = 1;
    expect_lvl(1, 1, "R10 restart");
    pkt = 0;
    expect_lvl(1, 3, "R10 full high phase");
    expect_lvl(0, 4, "R10 low phase");
    lctl = 1;
    expect_lvl(0, 4, "R4 control bit ends");

    // Packet while link up is forgotten; gated flag does nothing.
    pkt = 1;
    expect_lvl(0, 1, "R9 packet while up");
    pkt = 0; cfg = 1;
    expect_lvl(0, 2, "R9 still low");
    lctl = 0;
    expect_lvl(0, 8, "R9 R5 no wake");

    // Interrupt present while up fires when link drops; survives bus reset.
    lctl = 1; cfg = 0; cab = 1; ren = 1;
    expect_lvl(0, 4, "R8 held off while up");
    lctl = 0;
    expect_lvl(1, 4, "R8 fires on drop");
    expect_lvl(0, 2, "R8 low phase");
    brst = 1;
    expect_lvl(0, 1, "R7 irq bus reset");
    brst = 0;
    expect_lvl(0, 1, "R7 irq low phase");
    expect_lvl(1, 4, "R7 wave continues");
    cab = 0; ren = 0;
    expect_lvl(0, 4, "R6 after irq gone");
    brst = 1;
    expect_lvl(0, 1, "R7 drop no irq");
    brst = 0;
    expect_lvl(0, 6, "R10 low after end");

    // Second reset with pin low.
    rst = 1; pin = 0; st = 1; ren = 1;
    repeat (2) @(negedge clk);
    check(oe, 1'b0, "R2 oe in second reset");
    check(lkon, 1'b0, "R2 out in second reset");
    st = 0; ren = 0; rst = 0; pin = 1;
    @(negedge clk);
    check(cont, 1'b0, "R3 contender low");
    repeat (3) @(negedge clk);
    check(cont, 1'b0, "R3 contender held");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule